// File: doc/BRIEF.md
# Paged Expanded Data RAM

This block places a 768-byte on-chip RAM at the bottom of the external data address space of an 8051-style processor core. It decodes every data-space access from the core and decides whether the access is served by the internal array or passed to the external memory bus. An access that carries a full 16-bit pointer addresses the internal window directly. An access that carries only an 8-bit register pointer takes its upper address bits from a page register. This steers the access into one of three 256-byte pages.

Two configuration registers sit behind a small byte-wide register port. A control register holds an enable bit. Clearing that bit hands the whole range to the external bus. A page register holds the two page bits. Read data for any read, internal or external, is returned to the core one clock after the request.

Top module: `exram_paged`

## Requirements
- R1: With the enable bit set, a 16-bit-pointer access to an address from 0x0000 to 0x02FF hits the internal RAM. `acc_hit` is high and `ext_req` is low during the request cycle. For a read, the addressed byte appears on `acc_rdata` in the following cycle.
- R2: The control register (`sfr_sel` = 0) keeps the enable bit in bit 1. After reset this bit is 1, so the register reads 0x02.
- R3: The page register (`sfr_sel` = 1) keeps the page in bits 1:0 and reads 0x00 after reset. Its contents, like the enable bit, change only on a register write or a reset.
- R4: An 8-bit-pointer access (`acc_short` = 1) goes to address page×256 plus `acc_addr[7:0]`. Page 00 gives 0x0000–0x00FF, 01 gives 0x0100–0x01FF and 10 gives 0x0200–0x02FF. Bits 15:8 of `acc_addr` are ignored.
- R5: An 8-bit-pointer access with page 11 does not hit. It is sent to the external bus with `ext_addr` = 0x0300 + `acc_addr[7:0]`.
- R6: While the enable bit is 0, every access goes to the external bus and the internal contents are left untouched. Setting the bit again makes the earlier contents visible.
- R7: A 16-bit-pointer access at 0x0300 or above goes to the external bus with `ext_addr` equal to `acc_addr`. For a read, `acc_rdata` in the next cycle equals `ext_rdata`.
- R8: A write to the internal RAM takes effect at the clock edge that ends the request cycle. A read of the same address in the very next cycle returns the new byte.
- R9: Register bits other than the enable bit and the page bits read as 0, and writing them has no effect.
- R10: A 16-bit-pointer access ignores the page register.
- R11: An external access presents `ext_we` equal to `acc_we` and `ext_wdata` equal to `acc_wdata`. An internal hit never raises `ext_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_sel | input | 1 | Register select: 0 control, 1 page |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| acc_req | input | 1 | Data access request, one cycle |
| acc_we | input | 1 | Access is a write |
| acc_short | input | 1 | Access uses an 8-bit pointer |
| acc_addr | input | 16 | Access address (low byte only when short) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read |
| acc_hit | output | 1 | Access is served internally |
| ext_req | output | 1 | Access forwarded to the external bus |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 16 | Resolved access address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, valid the cycle after the request |

## Verification
The assertions watch the routing rules on every cycle:
- a disabled block, a page-11 short access and a long address of 0x0300 or above must each raise an external request;
- the RAM is never enabled outside its 768 bytes;
- the configuration registers hold still without a write;
- read data after an external read follows the external port.

Only the scenarios in the bench can show that the bytes come back from the right location:
- which page a short pointer really reaches;
- that a write is visible in the next cycle;
- that contents survive a disable and re-enable;
- that the unused register bits stay at zero.

// File: rtl/exram_pkg.sv
`timescale 1ns/1ps
package exram_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int EN_BIT = 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_PAGE = 1'b1
  } sfr_sel_e;

  // Address of the first byte of a page
  function automatic addr_t page_base(input addr_t page, input int unsigned ofs_w);
    return addr_t'(page << ofs_w);
  endfunction

  // True when an address falls inside the internal window
  function automatic logic in_window(input addr_t a, input int unsigned depth);
    return ({16'b0, a} < depth);
  endfunction
endpackage

// File: rtl/exram_sfr.sv
`timescale 1ns/1ps
module exram_sfr
  import exram_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  data_t             wdata,
  output data_t             rdata,
  output logic              en,
  output logic [PAGE_W-1:0] page
);
  logic              en_q;
  logic [PAGE_W-1:0] page_q;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      page_q <= '0;
    end else if (we) begin
      if (sel == SEL_CTRL) en_q <= wdata[EN_BIT];
      else                 page_q <= wdata[PAGE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_CTRL) rdata[EN_BIT] = en_q;
    else                 rdata[PAGE_W-1:0] = page_q;
  end

  assign en   = en_q;
  assign page = page_q;

  // R3: configuration only moves on a write
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(page_q) && $stable(en_q)));
endmodule

// File: rtl/exram_route.sv
`timescale 1ns/1ps
module exram_route
  import exram_pkg::*;
#(
  parameter int DEPTH      = 768,
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              short_ptr,
  input  addr_t             addr,
  input  logic              en,
  input  logic [PAGE_W-1:0] page,
  output addr_t             eff_addr,
  output logic              hit,
  output logic              ext_req,
  output logic              ext_we
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  function automatic addr_t resolve(input logic s, input logic [PAGE_W-1:0] pg, input addr_t a);
    addr_t ofs_mask;
    ofs_mask = addr_t'(PAGE_BYTES - 1);
    if (s) return page_base(addr_t'(pg), OFS_W) | (a & ofs_mask);
    return a;
  endfunction

  assign eff_addr = resolve(short_ptr, page, addr);
  assign hit      = req && en && in_window(eff_addr, DEPTH);
  assign ext_req  = req && !hit;
  assign ext_we   = ext_req && we;

  // R6: disabled block hands every access out
  assert_disable_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !en) |-> ext_req);

  // R5: page 11 short access misses with 0x03xx
  assert_page3_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && short_ptr && (page == '1) && (PAGE_W == 2)) |->
      (ext_req && eff_addr[ADDR_W-1:OFS_W] == addr_t'(3)));

  // R7: long access above the window goes out unchanged
  assert_high_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !short_ptr && addr >= addr_t'(DEPTH)) |-> (ext_req && eff_addr == addr));
endmodule

// File: rtl/exram_array.sv
`timescale 1ns/1ps
module exram_array
  import exram_pkg::*;
#(
  parameter int DEPTH = 768
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  data_t                    wdata,
  output data_t                    rdata
);
  data_t mem [DEPTH];
  data_t q;

  always_ff @(posedge clk) begin
    if (ce && we) mem[idx] <= wdata;
    if (ce && !we) q <= mem[idx];
  end

  assign rdata = q;

  // R1: the array is only touched inside its 768 bytes
  assert_ce_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce |-> ({1'b0, idx} < ($clog2(DEPTH)+1)'(DEPTH)));
endmodule

// File: rtl/exram_paged.sv
`timescale 1ns/1ps
module exram_paged
  import exram_pkg::*;
#(
  parameter int DEPTH      = 768,
  parameter int PAGE_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_sel,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        acc_req,
  input  logic        acc_we,
  input  logic        acc_short,
  input  logic [15:0] acc_addr,
  input  logic [7:0]  acc_wdata,
  output logic [7:0]  acc_rdata,
  output logic        acc_hit,
  output logic        ext_req,
  output logic        ext_we,
  output logic [15:0] ext_addr,
  output logic [7:0]  ext_wdata,
  input  logic [7:0]  ext_rdata
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int PAGE_W = $clog2((DEPTH + PAGE_BYTES - 1) / PAGE_BYTES);

  logic              en;
  logic [PAGE_W-1:0] page;
  addr_t             eff_addr;
  logic              hit;
  data_t             ram_q;
  logic              rd_hit_q;

  exram_sfr #(.PAGE_W(PAGE_W)) u_sfr (
    .clk(clk), .rst_n(rst_n), .sel(sfr_sel), .we(sfr_we),
    .wdata(sfr_wdata), .rdata(sfr_rdata), .en(en), .page(page)
  );

  exram_route #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W)) u_route (
    .clk(clk), .rst_n(rst_n), .req(acc_req), .we(acc_we), .short_ptr(acc_short),
    .addr(acc_addr), .en(en), .page(page), .eff_addr(eff_addr),
    .hit(hit), .ext_req(ext_req), .ext_we(ext_we)
  );

  exram_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_n), .ce(hit), .we(acc_we),
    .idx(eff_addr[IDX_W-1:0]), .wdata(acc_wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_hit_q <= 1'b0;
    else if (acc_req && !acc_we) rd_hit_q <= hit;
  end

  assign acc_rdata = rd_hit_q ? ram_q : ext_rdata;
  assign acc_hit   = hit;
  assign ext_addr  = eff_addr;
  assign ext_wdata = acc_wdata;

  // R7: a read sent out returns the external byte next cycle
  assert_ext_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_we && ext_req) |=> (acc_rdata == ext_rdata));
endmodule

// File: tb/exram_paged_tb.sv
`timescale 1ns/1ps
module exram_paged_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_sel = 1'b0, sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        acc_req = 1'b0, acc_we = 1'b0, acc_short = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0, acc_rdata;
  logic        acc_hit, ext_req, ext_we;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  exram_paged u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .acc_req(acc_req),
    .acc_we(acc_we), .acc_short(acc_short), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_hit(acc_hit),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  typedef struct packed {
    logic [1:0]  pg;
    logic        sh;
    logic        wr;
    logic [15:0] ad;
    logic [7:0]  wd;
    logic        hit;
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 1'b1, 16'h0010, 8'h11, 1'b1, 8'h00},
    '{2'd0, 1'b0, 1'b1, 16'h0110, 8'h22, 1'b1, 8'h00},
    '{2'd0, 1'b0, 1'b1, 16'h0210, 8'h33, 1'b1, 8'h00},
    '{2'd0, 1'b0, 1'b1, 16'h02FF, 8'h44, 1'b1, 8'h00},
    '{2'd0, 1'b0, 1'b1, 16'h0300, 8'h55, 1'b0, 8'h00},
    '{2'd0, 1'b1, 1'b0, 16'h0010, 8'h00, 1'b1, 8'h11},
    '{2'd1, 1'b1, 1'b0, 16'h0010, 8'h00, 1'b1, 8'h22},
    '{2'd2, 1'b1, 1'b0, 16'h0010, 8'h00, 1'b1, 8'h33},
    '{2'd2, 1'b1, 1'b0, 16'h00FF, 8'h00, 1'b1, 8'h44},
    '{2'd3, 1'b1, 1'b0, 16'h0010, 8'h00, 1'b0, 8'h4A},
    '{2'd1, 1'b0, 1'b0, 16'h0010, 8'h00, 1'b1, 8'h11},
    '{2'd1, 1'b0, 1'b0, 16'h0300, 8'h00, 1'b0, 8'h5A},
    '{2'd1, 1'b1, 1'b1, 16'h0080, 8'h66, 1'b1, 8'h00},
    '{2'd1, 1'b0, 1'b0, 16'h0180, 8'h00, 1'b1, 8'h66},
    '{2'd2, 1'b1, 1'b0, 16'hAB10, 8'h00, 1'b1, 8'h33}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sfr_write(input logic sel, input logic [7:0] v);
    @(negedge clk);
    sfr_sel = sel; sfr_we = 1'b1; sfr_wdata = v;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    sfr_sel = sel;
    #1 v = sfr_rdata;
  endtask

  // One access: routing sampled in the request cycle, data one cycle later
  task automatic access(input logic s, input logic w, input logic [15:0] a, input logic [7:0] d,
                        output logic h, output logic x, output logic xw,
                        output logic [15:0] xa, output logic [7:0] xd, output logic [7:0] r);
    @(negedge clk);
    acc_req = 1'b1; acc_we = w; acc_short = s; acc_addr = a; acc_wdata = d;
    ext_rdata = a[7:0] ^ 8'h5A;
    #1;
    h = acc_hit; x = ext_req; xw = ext_we; xa = ext_addr; xd = ext_wdata;
    @(negedge clk);
    r = acc_rdata;
    acc_req = 1'b0; acc_we = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v, r, xd;
    logic h, x, xw;
    logic [15:0] xa;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state R2, R3
    sfr_read(1'b0, v); check("R2 ctrl reset", {8'h0, v}, 16'h0002);
    sfr_read(1'b1, v); check("R3 page reset", {8'h0, v}, 16'h0000);
    check("R11 idle ext_req", {15'h0, ext_req}, 16'h0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      sfr_write(1'b1, {6'b0, TBL[i].pg});
      access(TBL[i].sh, TBL[i].wr, TBL[i].ad, TBL[i].wd, h, x, xw, xa, xd, r);
      if (TBL[i].sh) tag = (TBL[i].pg == 2'd3) ? "R5" : "R4";
      else if (TBL[i].ad >= 16'h0300) tag = "R7";
      else if (TBL[i].pg != 2'd0) tag = "R10";
      else tag = TBL[i].wr ? "R8" : "R1";
      check({tag, " hit"}, {15'h0, h}, {15'h0, TBL[i].hit});
      check({"R11 ", tag, " ext_req"}, {15'h0, x}, {15'h0, !TBL[i].hit});
      if (!TBL[i].hit) begin
        check({tag, " ext_addr"}, xa,
              TBL[i].sh ? {6'b0, TBL[i].pg, TBL[i].ad[7:0]} : TBL[i].ad);
        check({"R11 ", tag, " ext_we"}, {15'h0, xw}, {15'h0, TBL[i].wr});
        if (TBL[i].wr) check({"R11 ", tag, " ext_wdata"}, {8'h0, xd}, {8'h0, TBL[i].wd});
      end
      if (!TBL[i].wr) check({tag, " rdata"}, {8'h0, r}, {8'h0, TBL[i].rd});
    end

    // R8: write then read in the very next request
    access(1'b0, 1'b1, 16'h0005, 8'h77, h, x, xw, xa, xd, r);
    access(1'b0, 1'b0, 16'h0005, 8'h00, h, x, xw, xa, xd, r);
    check("R8 back-to-back read", {8'h0, r}, 16'h0077);

    // R9: unused register bits
    sfr_write(1'b1, 8'hFC); sfr_read(1'b1, v); check("R9 page upper bits", {8'h0, v}, 16'h0000);
    sfr_write(1'b1, 8'hFF); sfr_read(1'b1, v); check("R9 page readback", {8'h0, v}, 16'h0003);
    sfr_write(1'b0, 8'hFF); sfr_read(1'b0, v); check("R9 ctrl readback", {8'h0, v}, 16'h0002);
    sfr_write(1'b1, 8'h00);

    // R6: disable hands everything out and keeps contents
    sfr_write(1'b0, 8'hFD); sfr_read(1'b0, v); check("R6 R9 ctrl cleared", {8'h0, v}, 16'h0000);
    access(1'b0, 1'b0, 16'h0010, 8'h00, h, x, xw, xa, xd, r);
    check("R6 disabled hit", {15'h0, h}, 16'h0000);
    check("R6 disabled ext_req", {15'h0, x}, 16'h0001);
    check("R6 disabled rdata", {8'h0, r}, 16'h004A);
    access(1'b0, 1'b1, 16'h0010, 8'h99, h, x, xw, xa, xd, r);
    check("R6 R11 disabled ext_we", {15'h0, xw}, 16'h0001);
    check("R6 R11 disabled ext_wdata", {8'h0, xd}, 16'h0099);
    access(1'b1, 1'b0, 16'h0010, 8'h00, h, x, xw, xa, xd, r);
    check("R6 disabled short ext_req", {15'h0, x}, 16'h0001);
    sfr_write(1'b0, 8'h02);
    access(1'b0, 1'b0, 16'h0010, 8'h00, h, x, xw, xa, xd, r);
    check("R6 contents retained", {8'h0, r}, 16'h0011);

    // R2, R3: a second reset restores the register defaults
    sfr_write(1'b1, 8'h02);
    sfr_write(1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    sfr_read(1'b0, v); check("R2 ctrl after reset", {8'h0, v}, 16'h0002);
    sfr_read(1'b1, v); check("R3 page after reset", {8'h0, v}, 16'h0000);
    access(1'b1, 1'b0, 16'h0010, 8'h00, h, x, xw, xa, xd, r);
    check("R4 page0 after reset", {8'h0, r}, 16'h0011);

    summary();
  end
endmodule